// File: doc/BRIEF.md
# Paging Control Register Unit

This block keeps the three paging control registers of a 32-bit core (the mode register, the page-table base register and the feature register) and the state of the address-bit-20 gate. The core writes these registers through one write port: a select, a 32-bit data word and a strobe. The block also derives a set of hidden mode flags from the mode register. These are the protection flag, the segment-add flag and three floating-point control flags. It gives these flags and the current physical address mask to the rest of the core.

Some writes change state that address translation depends on. Each such write makes the block raise a one-cycle request to the translation cache. The request is either a full flush or a flush of non-global entries only. Requests are raised only when the bits that matter actually change. Writes that leave those bits alone raise nothing.

Top module: `pgc_top`

## Requirements
- R1: After reset: `ctl0_o` = 0x60000010, `ctl3_o` = 0, `ctl4_o` = 0, `addr_mask_o` = 0xFFFFFFFF, `prot_o` = 0, `seg_add_o` = 1, `fpu_o` = 0, and both flush outputs low.
- R2: A write with `wr_sel_i` = 0 (mode register) stores `wr_data_i` with bit 4 forced to 1. The new value is visible on `ctl0_o` in the cycle after the write edge.
- R3: A mode-register write pulses `flush_all_o` in the next cycle only if bit 31 (paging), bit 16 (write protect) or bit 0 (protection) of the written data differs from the stored value.
- R4: After a mode-register write, `prot_o` equals the written bit 0 and `seg_add_o` equals its inverse. `fpu_o` equals written bits [3:1], with bit 1 on `fpu_o[0]`.
- R5: A write with `wr_sel_i` = 1 always stores the data on `ctl3_o`. It pulses `flush_local_o` in the next cycle only if bit 31 of the stored mode register is set when the write happens.
- R6: A write with `wr_sel_i` = 2 stores the data on `ctl4_o`. It pulses `flush_all_o` only if bit 7, bit 5 or bit 4 changes.
- R7: A write with `wr_sel_i` = 3 sets the gate to 1 if the data is nonzero and to 0 otherwise. `addr_mask_o` becomes 0xFFEFFFFF with bit 20 equal to the gate. A change of gate state pulses `flush_all_o`. Writing the current state changes nothing.
- R8: Flush outputs are one-cycle pulses that are never high together; a full flush wins over a local flush.
- R9: A cycle with `wr_en_i` low changes no register, flag or mask and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Target: 0 mode, 1 table base, 2 feature, 3 gate |
| wr_data_i | input | 32 | Write data |
| ctl0_o | output | 32 | Mode register |
| ctl3_o | output | 32 | Page-table base register |
| ctl4_o | output | 32 | Feature register |
| addr_mask_o | output | 32 | Physical address mask |
| prot_o | output | 1 | Hidden protection flag |
| seg_add_o | output | 1 | Hidden segment-add flag |
| fpu_o | output | 3 | Hidden floating-point control flags |
| flush_all_o | output | 1 | Full flush request pulse |
| flush_local_o | output | 1 | Non-global flush request pulse |

## Verification
Two things can meet in the same cycle: the full-flush pulse from a mode-register write that turns paging on or off, and a table-base write issued on the very next edge. The table-base write must already see the new paging bit. The bench provokes this in both directions with back-to-back writes. When paging has just been turned off, it checks that no local flush follows. When paging has just been turned on, it checks that the full and local pulses land in adjacent cycles and never overlap.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [1:0] {
    SEL_CTL0 = 2'd0,
    SEL_CTL3 = 2'd1,
    SEL_CTL4 = 2'd2,
    SEL_GATE = 2'd3
  } sel_e;

  localparam logic [XLEN-1:0] CTL0_RST   = 32'h6000_0010;
  localparam logic [XLEN-1:0] CTL0_FORCE = 32'h0000_0010;
  localparam logic [XLEN-1:0] CTL0_XLAT  = 32'h8001_0001;
  localparam logic [XLEN-1:0] CTL4_XLAT  = 32'h0000_00B0;
  localparam int unsigned     PG_BIT     = 31;
  localparam int unsigned     GATE_BIT   = 20;
endpackage

// File: rtl/pgc_ctl0.sv
module pgc_ctl0
  import pgc_pkg::*;
#(
  parameter logic [XLEN-1:0] RST_VAL   = CTL0_RST,
  parameter logic [XLEN-1:0] FORCE_SET = CTL0_FORCE,
  parameter logic [XLEN-1:0] XLAT_MASK = CTL0_XLAT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] data_i,
  output logic [XLEN-1:0] q_o,
  output logic            prot_o,
  output logic            seg_add_o,
  output logic [2:0]      fpu_o,
  output logic            flush_req_o
);
  logic [XLEN-1:0] q_q;

  assign flush_req_o = we_i && ((data_i & XLAT_MASK) != (q_q & XLAT_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q       <= RST_VAL;
      prot_o    <= RST_VAL[0];
      seg_add_o <= ~RST_VAL[0];
      fpu_o     <= RST_VAL[3:1];
    end else if (we_i) begin
      q_q       <= data_i | FORCE_SET;
      prot_o    <= data_i[0];
      seg_add_o <= ~data_i[0];
      fpu_o     <= data_i[3:1];
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/pgc_creg.sv
// MODE 0: flush on change of masked bits; MODE 1: flush whenever paging is on.
module pgc_creg
  import pgc_pkg::*;
#(
  parameter int unsigned     MODE      = 0,
  parameter logic [XLEN-1:0] RST_VAL   = '0,
  parameter logic [XLEN-1:0] XLAT_MASK = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] data_i,
  input  logic            paging_i,
  output logic [XLEN-1:0] q_o,
  output logic            flush_req_o
);
  logic [XLEN-1:0] q_q;

  generate
    if (MODE == 1) begin : g_on_paging
      assign flush_req_o = we_i && paging_i;
    end else begin : g_on_change
      assign flush_req_o = we_i && ((data_i & XLAT_MASK) != (q_q & XLAT_MASK));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= RST_VAL;
    else if (we_i) q_q <= data_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/pgc_gate.sv
module pgc_gate
  import pgc_pkg::*;
#(
  parameter int unsigned GBIT = GATE_BIT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] data_i,
  output logic [XLEN-1:0] mask_o,
  output logic            flush_req_o
);
  localparam logic [XLEN-1:0] CLR = ~(XLEN'(1) << GBIT);

  logic gate_q;
  logic gate_d;

  assign gate_d      = |data_i;
  assign flush_req_o = we_i && (gate_d != gate_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   gate_q <= 1'b1;
    else if (we_i) gate_q <= gate_d;
  end

  assign mask_o = CLR | (XLEN'(gate_q) << GBIT);
endmodule

// File: rtl/pgc_flush.sv
module pgc_flush #(
  parameter int unsigned N_ALL = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ALL-1:0] req_all_i,
  input  logic             req_local_i,
  output logic             flush_all_o,
  output logic             flush_local_o
);
  logic any_all;
  assign any_all = |req_all_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_all_o   <= 1'b0;
      flush_local_o <= 1'b0;
    end else begin
      flush_all_o   <= any_all;
      flush_local_o <= req_local_i && !any_all;  // full flush covers local
    end
  end
endmodule

// File: rtl/pgc_top.sv
module pgc_top
  import pgc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] ctl0_o,
  output logic [XLEN-1:0] ctl3_o,
  output logic [XLEN-1:0] ctl4_o,
  output logic [XLEN-1:0] addr_mask_o,
  output logic            prot_o,
  output logic            seg_add_o,
  output logic [2:0]      fpu_o,
  output logic            flush_all_o,
  output logic            flush_local_o
);
  logic we0, we3, we4, weg;
  logic req0, req3, req4, reqg;

  assign we0 = wr_en_i && (wr_sel_i == SEL_CTL0);
  assign we3 = wr_en_i && (wr_sel_i == SEL_CTL3);
  assign we4 = wr_en_i && (wr_sel_i == SEL_CTL4);
  assign weg = wr_en_i && (wr_sel_i == SEL_GATE);

  pgc_ctl0 u_ctl0 (
    .clk_i, .rst_ni, .we_i(we0), .data_i(wr_data_i), .q_o(ctl0_o),
    .prot_o, .seg_add_o, .fpu_o, .flush_req_o(req0)
  );

  pgc_creg #(.MODE(1), .RST_VAL('0), .XLAT_MASK('0)) u_ctl3 (
    .clk_i, .rst_ni, .we_i(we3), .data_i(wr_data_i),
    .paging_i(ctl0_o[PG_BIT]), .q_o(ctl3_o), .flush_req_o(req3)
  );

  pgc_creg #(.MODE(0), .RST_VAL('0), .XLAT_MASK(CTL4_XLAT)) u_ctl4 (
    .clk_i, .rst_ni, .we_i(we4), .data_i(wr_data_i),
    .paging_i(ctl0_o[PG_BIT]), .q_o(ctl4_o), .flush_req_o(req4)
  );

  pgc_gate u_gate (
    .clk_i, .rst_ni, .we_i(weg), .data_i(wr_data_i),
    .mask_o(addr_mask_o), .flush_req_o(reqg)
  );

  pgc_flush #(.N_ALL(3)) u_flush (
    .clk_i, .rst_ni, .req_all_i({req0, req4, reqg}), .req_local_i(req3),
    .flush_all_o, .flush_local_o
  );
endmodule

// File: rtl/pgc_chk.sv
module pgc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [1:0]  wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] ctl0_o,
  input logic [31:0] ctl3_o,
  input logic [31:0] ctl4_o,
  input logic [31:0] addr_mask_o,
  input logic        prot_o,
  input logic        seg_add_o,
  input logic        flush_all_o,
  input logic        flush_local_o
);
  p_force_bit4_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> ctl0_o == ($past(wr_data_i) | 32'h10));

  p_xlat_flush_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0 && ((wr_data_i ^ ctl0_o) & 32'h8001_0001) != 0)
    |=> flush_all_o);

  p_hidden_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> (prot_o == $past(wr_data_i[0])) && (seg_add_o != prot_o));

  p_base_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd1 && ctl0_o[31]) |=> flush_local_o);

  p_mask_shape_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_mask_o | 32'h0010_0000) == 32'hFFFF_FFFF);

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flush_all_o && flush_local_o));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !flush_all_o && !flush_local_o && $stable(ctl0_o) && $stable(ctl3_o)
                 && $stable(ctl4_o) && $stable(addr_mask_o));
endmodule

bind pgc_top pgc_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .ctl0_o, .ctl3_o, .ctl4_o,
  .addr_mask_o, .prot_o, .seg_add_o, .flush_all_o, .flush_local_o
);

// File: tb/sim_pgc_top.sv
`timescale 1ns/1ps
module sim_pgc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctl0, ctl3, ctl4, amask;
  logic        prot, segadd, fl_all, fl_loc;
  logic [2:0]  fpu;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  pgc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .ctl0_o(ctl0), .ctl3_o(ctl3), .ctl4_o(ctl4), .addr_mask_o(amask),
    .prot_o(prot), .seg_add_o(segadd), .fpu_o(fpu),
    .flush_all_o(fl_all), .flush_local_o(fl_loc)
  );

  // {sel, data, expected register value, exp full, exp local}
  localparam int NV = 13;
  localparam logic [67:0] VEC [NV] = '{
    {2'd1, 32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0},  // R5 paging off
    {2'd0, 32'h6000_0000, 32'h6000_0010, 1'b0, 1'b0},  // R2 R3
    {2'd0, 32'h0000_000F, 32'h0000_001F, 1'b1, 1'b0},  // R3 protection bit
    {2'd0, 32'h8000_000B, 32'h8000_001B, 1'b1, 1'b0},  // R3 paging bit
    {2'd1, 32'h0000_2000, 32'h0000_2000, 1'b0, 1'b1},  // R5 paging on
    {2'd2, 32'h0000_0008, 32'h0000_0008, 1'b0, 1'b0},  // R6 irrelevant bit
    {2'd2, 32'h0000_0018, 32'h0000_0018, 1'b1, 1'b0},  // R6 bit 4
    {2'd2, 32'h0000_0098, 32'h0000_0098, 1'b1, 1'b0},  // R6 bit 7
    {2'd3, 32'h0000_0000, 32'hFFEF_FFFF, 1'b1, 1'b0},  // R7 close
    {2'd3, 32'h0000_0000, 32'hFFEF_FFFF, 1'b0, 1'b0},  // R7 same state
    {2'd3, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0},  // R7 nonzero opens
    {2'd0, 32'h8001_001B, 32'h8001_001B, 1'b1, 1'b0},  // R3 write-protect bit
    {2'd0, 32'h8001_001B, 32'h8001_001B, 1'b0, 1'b0}   // R3 no change
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] reg_of(input logic [1:0] s);
    case (s)
      2'd0: return ctl0;
      2'd1: return ctl3;
      2'd2: return ctl4;
      default: return amask;
    endcase
  endfunction

  // write on one edge, sample at the following negedge
  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctl0", ctl0, 32'h6000_0010);
    chk("R1 ctl3", ctl3, 32'h0);
    chk("R1 ctl4", ctl4, 32'h0);
    chk("R1 mask", amask, 32'hFFFF_FFFF);
    chk("R1 flags", {29'b0, prot, segadd, fl_all}, 32'h2);
    chk("R1 fpu/local", {28'b0, fpu, fl_loc}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][67:66], VEC[i][65:34]);
      chk($sformatf("R2-7 vec%0d reg", i), reg_of(VEC[i][67:66]), VEC[i][33:2]);
      chk($sformatf("R3 R5 R6 R7 vec%0d flush", i), {30'b0, fl_all, fl_loc}, {30'b0, VEC[i][1:0]});
      @(negedge clk);
      chk($sformatf("R8 vec%0d pulse ends", i), {30'b0, fl_all, fl_loc}, 32'h0);
    end

    // R4 hidden flags
    wr(2'd0, 32'h0000_0004);
    chk("R4 prot/segadd", {30'b0, prot, segadd}, 32'h1);
    chk("R4 fpu", {29'b0, fpu}, 32'h2);
    wr(2'd0, 32'h0000_0009);
    chk("R4 prot/segadd pe", {30'b0, prot, segadd}, 32'h2);
    chk("R4 fpu 100", {29'b0, fpu}, 32'h4);

    // R9 idle cycles change nothing
    wr_data = 32'hFFFF_FFFF; wr_sel = 2'd3;
    repeat (3) @(negedge clk);
    chk("R9 ctl0", ctl0, 32'h0000_0019);
    chk("R9 mask", amask, 32'hFFFF_FFFF);
    chk("R9 flush", {30'b0, fl_all, fl_loc}, 32'h0);

    // back-to-back: paging on then base write (R5 R8)
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h8000_0011;
    @(negedge clk);
    wr_sel = 2'd1; wr_data = 32'h0000_3000;
    chk("R8 b2b full first", {30'b0, fl_all, fl_loc}, 32'h2);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 b2b local second", {30'b0, fl_all, fl_loc}, 32'h1);
    chk("R5 b2b base stored", ctl3, 32'h0000_3000);

    // back-to-back: paging off then base write, no local flush (R5)
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h0000_0011;
    @(negedge clk);
    wr_sel = 2'd1; wr_data = 32'h0000_4000;
    chk("R3 b2b off full", {30'b0, fl_all, fl_loc}, 32'h2);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 b2b off no local", {30'b0, fl_all, fl_loc}, 32'h0);
    chk("R5 b2b off base stored", ctl3, 32'h0000_4000);

    done = 1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      finish_run();
    end
  end
endmodule